// File: doc/BRIEF.md
# Synchronous Serial Interface Slave with Monoflop Timeout

This block answers a master that reads a sensor word over a two-wire synchronous serial link: one clock line driven by the master and one data line driven by this slave. Both lines idle high. The block samples the master clock with its own system clock, finds the edges and shifts out a fixed-length word, most significant bit first. It does not use a select line. A frame ends with one extra clock pulse after the data bits and then a stretch of clock inactivity, the monoflop time.

Local logic loads a new parallel word into a holding register through a valid/ready strobe at any moment. The word is copied into the shift register only at the first falling clock edge of a frame, while the slave is idle. A word loaded during a frame therefore never disturbs that frame. A timeout counter in system clock cycles closes each frame. It also clears a frame that the master abandons partway, so the next frame always starts again at the top bit.

Top module: `ssi_slave`

## Requirements
- R1: After reset the data output is high and loadReady is high.
- R2: The first falling edge of the serial clock in idle copies the holding register into the shift register. Rising edges 1 to DATA_W then drive the word onto sdoOut, most significant bit first, one bit per rising edge.
- R3: The rising edge of the extra pulse (rising edge DATA_W+1) drives sdoOut low and puts out no bit of any word. Any further clock pulses before the timeout keep sdoOut low.
- R4: Once a frame has started, sdoOut goes back high after TIMEOUT_CYC system cycles with no detected serial clock edge, and the slave returns to idle.
- R5: Every detected serial clock edge restarts the timeout. A pause mid-frame that is shorter than the timeout leaves the frame intact.
- R6: If the master stops partway through a frame, the timeout returns sdoOut high. The next frame starts again at the most significant bit, with no leftover offset.
- R7: A word accepted while a frame is in progress does not change the bits of that frame. It is sent in the next frame.
- R8: loadReady is low for exactly one system cycle: the cycle that begins at the second rising system clock edge after the serial clock falls in idle. A word offered in that cycle is not taken. The frame sends the previously held word, and the word accepted in the next cycle goes out in the following frame.
- R9: Frames that follow each other, separated only by the timeout, deliver the same held word identically, with no drift of bits.
- R10: A rising serial clock edge while idle, with no falling edge first, is ignored, and sdoOut stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rstN | input | 1 | Active-low reset |
| sclkIn | input | 1 | Serial clock from the master, idle high, asynchronous |
| loadValid | input | 1 | Local logic offers a new word |
| loadData | input | DATA_W | Word offered for the next frame |
| loadReady | output | 1 | Holding register accepts a word this cycle |
| sdoOut | output | 1 | Serial data to the master, idle high |

## Verification
Two functions can fall in the same system cycle: local logic loading the holding register, and the frame start copying that register into the shift register. The bench creates this collision by driving the serial clock low on a known cycle and raising loadValid with a new word in exactly the cycle it predicts for the snapshot. It then checks that loadReady is low in that cycle and high in the next. It judges the result from the data line: the current frame must carry the previously held word, and the frame after it must carry the word accepted one cycle late.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  // Strobes from the control to the datapath; at most one is active per cycle
  typedef struct packed {
    logic latch;   // copy holding word into shift register
    logic shift;   // drive next bit, advance shift register
    logic drvLow;  // extra pulse seen: hold line low
    logic goIdle;  // timeout: release line high
  } ssiStb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } ssiState_t;

endpackage

// File: rtl/ssi_ctrl.sv
module ssi_ctrl
  import ssi_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int TIMEOUT_CYC = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  output ssiStb_t stb
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT_CYC - 1);

  // Synchronizer chain plus one history flop for edge detection
  logic [SYNC_STAGES:0] syncQ;
  logic sclkNow, sclkPrev, fallSeen, riseSeen, anyEdge, timerDone;

  ssiState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt;
  logic [TMR_W-1:0] idleTmr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], sclkIn};
  end

  assign sclkNow   = syncQ[SYNC_STAGES-1];
  assign sclkPrev  = syncQ[SYNC_STAGES];
  assign fallSeen  = sclkPrev & ~sclkNow;
  assign riseSeen  = ~sclkPrev & sclkNow;
  assign anyEdge   = fallSeen | riseSeen;
  assign timerDone = (idleTmr == TMR_LAST);

  always_comb begin
    stb      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (fallSeen) begin
          stb.latch = 1'b1;
          stateNxt  = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (riseSeen) begin
          if (bitCnt == BIT_LAST) begin
            stb.drvLow = 1'b1;
            stateNxt   = ST_TAIL;
          end else begin
            stb.shift = 1'b1;
          end
        end else if (!anyEdge && timerDone) begin
          stb.goIdle = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      ST_TAIL: begin
        if (!anyEdge && timerDone) begin
          stb.goIdle = 1'b1;
          stateNxt   = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      idleTmr <= '0;
    end else begin
      state <= stateNxt;
      if (stb.latch || stb.goIdle) bitCnt <= '0;
      else if (stb.shift)          bitCnt <= bitCnt + 1'b1;
      if (state == ST_IDLE || anyEdge || stb.goIdle) idleTmr <= '0;
      else if (!timerDone)                           idleTmr <= idleTmr + 1'b1;
    end
  end

endmodule

// File: rtl/ssi_dpath.sv
module ssi_dpath
  import ssi_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssiStb_t           stb,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  output logic              loadReady,
  output logic              sdoOut
);

  logic [DATA_W-1:0] holdReg, shiftReg;
  logic sdoReg, accept;

  // The holding register is busy only in the snapshot cycle
  assign loadReady = ~stb.latch;
  assign accept    = loadValid & loadReady;
  assign sdoOut    = sdoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdReg <= '0;
    else if (accept) holdReg <= loadData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoReg   <= 1'b1;
    end else begin
      if (stb.latch) begin
        shiftReg <= holdReg;
      end else if (stb.shift) begin
        sdoReg   <= shiftReg[DATA_W-1];
        shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
      end
      if (stb.drvLow) sdoReg <= 1'b0;
      if (stb.goIdle) sdoReg <= 1'b1;
    end
  end

endmodule

// File: rtl/ssi_slave.sv
module ssi_slave
  import ssi_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int TIMEOUT_CYC = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              loadValid,
  input  logic [DATA_W-1:0] loadData,
  output logic              loadReady,
  output logic              sdoOut
);

  ssiStb_t stb;

  ssi_ctrl #(
    .DATA_W(DATA_W), .TIMEOUT_CYC(TIMEOUT_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .stb(stb)
  );

  ssi_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .loadValid(loadValid), .loadData(loadData),
    .loadReady(loadReady), .sdoOut(sdoOut)
  );

endmodule

// File: rtl/ssi_slave_chk.sv
module ssi_slave_chk
  import ssi_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    sdoOut,
  input logic    loadReady,
  input ssiStb_t stb
);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (sdoOut && loadReady));

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.latch, stb.shift, stb.drvLow, stb.goIdle}));

  p_tail_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.drvLow |=> !sdoOut);

  p_release_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.goIdle |=> sdoOut);

  p_start_from_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.latch |-> sdoOut);

  p_ready_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    !loadReady |=> loadReady);

endmodule

bind ssi_slave ssi_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sdoOut(sdoOut), .loadReady(loadReady), .stb(stb)
);

// File: tb/ssi_slave_tb.sv
`timescale 1ns/1ps
module ssi_slave_tb;

  localparam int W   = 24;
  localparam int TMO = 64;
  localparam int HP  = 8;   // serial half period in system cycles

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b1, lv = 1'b0;
  logic [W-1:0] ld = '0;
  logic lr, sdo;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ssi_slave #(.DATA_W(W), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclk), .loadValid(lv),
    .loadData(ld), .loadReady(lr), .sdoOut(sdo)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadWord(input logic [W-1:0] w);
    @(negedge clk); lv = 1'b1; ld = w;
    @(negedge clk); lv = 1'b0;
  endtask

  task automatic fallEdge(); sclk = 1'b0; waitCyc(HP); endtask
  task automatic riseEdge(); sclk = 1'b1; waitCyc(HP); endtask
  task automatic waitIdle(); waitCyc(TMO + 16); endtask

  task automatic readFrame(input bit skipFall, input int gapAt, input int gapLen,
                           input int loadAt, input logic [W-1:0] loadW,
                           output logic [W-1:0] word, output logic tail);
    word = '0; tail = 1'b1;
    for (int i = 0; i <= W; i++) begin
      if (!(skipFall && i == 0)) fallEdge();
      riseEdge();
      if (i < W) word[W-1-i] = sdo; else tail = sdo;
      if (i == gapAt) waitCyc(gapLen);
      if (i == loadAt) begin lv = 1'b1; ld = loadW; waitCyc(1); lv = 1'b0; end
    end
  endtask

  task automatic t_reset();
    chk("R1", "sdo after reset", 32'(sdo), 32'd1);
    chk("R1", "ready after reset", 32'(lr), 32'd1);
  endtask

  task automatic t_frame();
    logic [W-1:0] w; logic t;
    loadWord(24'hA5C33C);
    readFrame(1'b0, -1, 0, -1, '0, w, t);
    chk("R2", "frame word", 32'(w), 32'h00A5C33C);
    chk("R3", "extra pulse level", 32'(t), 32'd0);
    fallEdge(); riseEdge(); fallEdge(); riseEdge();
    chk("R3", "spare pulses level", 32'(sdo), 32'd0);
    waitCyc(20);
    chk("R4", "low before timeout", 32'(sdo), 32'd0);
    waitCyc(60);
    chk("R4", "high after timeout", 32'(sdo), 32'd1);
  endtask

  task automatic t_gap();
    logic [W-1:0] w; logic t;
    loadWord(24'h13579B);
    readFrame(1'b0, 10, TMO - 24, -1, '0, w, t);
    chk("R5", "word across short pause", 32'(w), 32'h0013579B);
    chk("R5", "tail after short pause", 32'(t), 32'd0);
    waitIdle();
  endtask

  task automatic t_abort();
    logic [W-1:0] w; logic t;
    loadWord(24'hC0FFEE);
    for (int i = 0; i < 7; i++) begin fallEdge(); riseEdge(); end
    fallEdge();
    waitIdle();
    chk("R6", "high after aborted frame", 32'(sdo), 32'd1);
    riseEdge();
    chk("R10", "idle rise ignored", 32'(sdo), 32'd1);
    waitCyc(HP);
    chk("R10", "idle rise still ignored", 32'(sdo), 32'd1);
    readFrame(1'b0, -1, 0, -1, '0, w, t);
    chk("R6", "word after abort", 32'(w), 32'h00C0FFEE);
    waitIdle();
  endtask

  task automatic t_midload();
    logic [W-1:0] w; logic t;
    loadWord(24'h111111);
    readFrame(1'b0, -1, 0, 11, 24'h2ABCDE, w, t);
    chk("R7", "frame unaffected by load", 32'(w), 32'h00111111);
    waitIdle();
    readFrame(1'b0, -1, 0, -1, '0, w, t);
    chk("R7", "loaded word in next frame", 32'(w), 32'h002ABCDE);
    waitIdle();
  endtask

  task automatic t_collide();
    logic [W-1:0] w; logic t;
    loadWord(24'h0F1E2D);
    sclk = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R8", "ready low in snapshot cycle", 32'(lr), 32'd0);
    lv = 1'b1; ld = 24'h3C4B5A;
    @(negedge clk);
    chk("R8", "ready back high", 32'(lr), 32'd1);
    @(negedge clk); lv = 1'b0;
    waitCyc(HP - 3);
    readFrame(1'b1, -1, 0, -1, '0, w, t);
    chk("R8", "frame keeps old word", 32'(w), 32'h000F1E2D);
    waitIdle();
    readFrame(1'b0, -1, 0, -1, '0, w, t);
    chk("R8", "late word in next frame", 32'(w), 32'h003C4B5A);
    waitIdle();
  endtask

  task automatic t_b2b();
    logic [W-1:0] w; logic t;
    loadWord(24'h5A5A5B);
    for (int k = 0; k < 3; k++) begin
      readFrame(1'b0, -1, 0, -1, '0, w, t);
      chk("R9", "repeated frame word", 32'(w), 32'h005A5A5B);
      chk("R9", "repeated frame tail", 32'(t), 32'd0);
      waitCyc(TMO + 8);
    end
  endtask

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(2);
    t_reset();
    t_frame();
    t_gap();
    t_abort();
    t_midload();
    t_collide();
    t_b2b();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitCyc(150000);
    total++; bad++;
    $display("FAIL watchdog run hung actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule